// File: doc/BRIEF.md
# Dual-Comparator Timer with Waveform Output

This block is a free-running up-counter with two compare registers, called A and P. It runs in one of three modes. As a plain timer it only counts and raises flags. In compare-output mode it toggles an output pin each time the counter is cleared. In PWM mode the pin drives a rectangular waveform whose period and duty come from the two compare registers. The counter is 10 bits wide. The A register is 10 bits wide. The P register is 3 bits wide and is compared only against the counter's top three bits, so a P value of k stands for a count of k·128.

Configuration arrives on plain input pins: run enable, mode, output-level bit, polarity bit, register-role swap, clear-source select and the two compare values. The compare values go through shadow copies that reload only while the timer is stopped or on the cycle the counter clears, so a value changed in mid-period cannot glitch the waveform. Three sticky flags report A matches, P matches and counter wrap. Each flag is cleared by a one-cycle acknowledge strobe.

Top module: `dual_cmp_timer`

## Requirements
- R1: While `runEn` is 0 the counter is held at 0 and the shadow registers follow `cmpA`/`cmpP`. In compare and PWM modes the pin shows `outCtl ^ outPol`.
- R2: In timer or compare mode with `clrSelA`=1, the counter counts 0..shadowA and then returns to 0, so one period is shadowA+1 cycles.
- R3: In timer or compare mode with `clrSelA`=0 and shadowP≠0, the counter counts 0..shadowP·128 and then returns to 0.
- R4: When the P-based clear applies and shadowP=0, the counter runs through all 1024 values and wraps from 1023 to 0. `flagOvf` is set on every cycle in which the running counter sits at 1023.
- R5: In compare mode (`modeSel`=1) the pin starts at `outCtl` (before polarity) and inverts on every counter clear.
- R6: In PWM mode (`modeSel`=2) `clrSelA` is ignored. With `dutySwap`=0, P sets the period (as in R3/R4) and A sets the duty. With `dutySwap`=1, A sets the period (as in R2) and P·128 sets the duty. The waveform is active while count < duty.
- R7: In PWM mode the active level is `outCtl` and the inactive level is its complement. While stopped, the pin shows the active level.
- R8: In compare and PWM modes, `outPol`=1 inverts the pin.
- R9: In timer mode (`modeSel`=0 or 3) the pin is 0 whatever the values of `outCtl` and `outPol`.
- R10: `flagA` is set by a running A match (count = shadowA). `flagP` is set by a running P match (shadowP≠0 and count = shadowP·128). All three flags stay set until the matching acknowledge is 1. A set and an acknowledge in the same cycle leave the flag set.
- R11: A change to `cmpA`/`cmpP` while running takes effect only from the cycle after the next counter clear.
- R12: After reset all three flags are 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | 1 counts, 0 stops and clears |
| modeSel | input | 2 | 0/3 timer, 1 compare output, 2 PWM |
| outCtl | input | 1 | Initial level (compare) or active level (PWM) |
| outPol | input | 1 | 1 inverts the pin |
| dutySwap | input | 1 | PWM register roles: 0 P=period, 1 A=period |
| clrSelA | input | 1 | Clear source outside PWM: 1 A match, 0 P match/wrap |
| cmpA | input | 10 | Compare value A |
| cmpP | input | 3 | Compare value P (top three counter bits) |
| ackA | input | 1 | Clears flagA |
| ackP | input | 1 | Clears flagP |
| ackOvf | input | 1 | Clears flagOvf |
| timerPin | output | 1 | Timer output pin |
| flagA | output | 1 | Sticky A-match flag |
| flagP | output | 1 | Sticky P-match flag |
| flagOvf | output | 1 | Sticky wrap flag |

## Verification
The bench targets P=0, where a design that compares to zero instead of wrapping would stick at count 0 and toggle on every cycle rather than once every 1024 cycles. It rewrites A in mid-period, which exposes any design that lets the new value act at once, because the pin would then toggle earlier than expected. It runs PWM with `clrSelA` in both states and with the register roles swapped, which catches a clear source leaking into PWM mode or duty and period taken from the wrong register. Random acknowledges that land on the same cycle as a match show whether set takes priority over clear.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER     = 2'd0,
    MODE_CMP       = 2'd1,
    MODE_PWM       = 2'd2,
    MODE_TIMER_ALT = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic stopClr;    // hold counter at zero, track compare inputs
    logic periodClr;  // period boundary: restart count, reload shadows
  } tmrStrobe_t;
endpackage

// File: rtl/dct_datapath.sv
`timescale 1ns/1ps
module dct_datapath
  import dct_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int P_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [P_W-1:0]   cmpP,
  output logic             hitA,
  output logic             hitP,
  output logic             pZero,
  output logic             atMax,
  output logic             underA,
  output logic             underP
);
  localparam int LOW_W = CNT_W - P_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shA;
  logic [P_W-1:0]   shP;
  logic [CNT_W-1:0] pLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      shA <= '0;
      shP <= '0;
    end else if (strobe.stopClr || strobe.periodClr) begin
      cnt <= '0;
      shA <= cmpA;
      shP <= cmpP;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign pLimit = {shP, {LOW_W{1'b0}}};
  assign pZero  = (shP == '0);
  assign hitA   = (cnt == shA);
  assign hitP   = !pZero && (cnt == pLimit);
  assign atMax  = (cnt == CNT_MAX);
  assign underA = (cnt < shA);
  assign underP = (cnt < pLimit);

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (atMax && !strobe.stopClr) |=> (cnt == '0));

  a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stopClr && !strobe.periodClr) |=> ($stable(shA) && $stable(shP)));

  a_r1_stop_holds_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stopClr |=> (cnt == '0));
endmodule

// File: rtl/dct_ctrl.sv
`timescale 1ns/1ps
module dct_ctrl
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic [1:0] modeSel,
  input  logic       outCtl,
  input  logic       outPol,
  input  logic       dutySwap,
  input  logic       clrSelA,
  input  logic       ackA,
  input  logic       ackP,
  input  logic       ackOvf,
  input  logic       hitA,
  input  logic       hitP,
  input  logic       pZero,
  input  logic       atMax,
  input  logic       underA,
  input  logic       underP,
  output tmrStrobe_t strobe,
  output logic       timerPin,
  output logic       flagA,
  output logic       flagP,
  output logic       flagOvf
);
  localparam int N_FLAG = 3;

  tmrMode_e mode;
  logic isPwm, isCmp;
  logic useA, pEvent, clrEvent;
  logic tog;
  logic activeNow;
  logic [N_FLAG-1:0] setVec, ackVec, flagQ;

  assign mode   = tmrMode_e'(modeSel);
  assign isPwm  = (mode == MODE_PWM);
  assign isCmp  = (mode == MODE_CMP);

  // PWM ignores the clear select: the period register alone decides
  assign useA     = isPwm ? dutySwap : clrSelA;
  assign pEvent   = pZero ? atMax : hitP;
  assign clrEvent = useA ? hitA : pEvent;

  assign strobe.stopClr   = !runEn;
  assign strobe.periodClr = runEn && clrEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    tog <= 1'b0;
    else if (!runEn)              tog <= 1'b0;
    else if (isCmp && clrEvent)   tog <= ~tog;
  end

  assign activeNow = dutySwap ? underP : underA;

  always_comb begin
    case (mode)
      MODE_CMP: timerPin = outCtl ^ tog ^ outPol;
      MODE_PWM: timerPin = (runEn ? (activeNow ? outCtl : ~outCtl) : outCtl) ^ outPol;
      default:  timerPin = 1'b0;
    endcase
  end

  assign setVec = {runEn && atMax, runEn && hitP, runEn && hitA};
  assign ackVec = {ackOvf, ackP, ackA};

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else       q <= setVec[i] | (q & ~ackVec[i]);
    end
    assign flagQ[i] = q;

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (q && !ackVec[i]) |=> q);
    a_r10_flag_set: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> q);
  end

  assign flagA   = flagQ[0];
  assign flagP   = flagQ[1];
  assign flagOvf = flagQ[2];

  a_r5_toggle_on_clear: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && isCmp && clrEvent) |=> (tog != $past(tog)));
endmodule

// File: rtl/dual_cmp_timer.sv
`timescale 1ns/1ps
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int P_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [1:0]       modeSel,
  input  logic             outCtl,
  input  logic             outPol,
  input  logic             dutySwap,
  input  logic             clrSelA,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [P_W-1:0]   cmpP,
  input  logic             ackA,
  input  logic             ackP,
  input  logic             ackOvf,
  output logic             timerPin,
  output logic             flagA,
  output logic             flagP,
  output logic             flagOvf
);
  tmrStrobe_t strobe;
  logic hitA, hitP, pZero, atMax, underA, underP;

  dct_datapath #(.CNT_W(CNT_W), .P_W(P_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpA(cmpA), .cmpP(cmpP),
    .hitA(hitA), .hitP(hitP), .pZero(pZero), .atMax(atMax),
    .underA(underA), .underP(underP)
  );

  dct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .modeSel(modeSel),
    .outCtl(outCtl), .outPol(outPol), .dutySwap(dutySwap), .clrSelA(clrSelA),
    .ackA(ackA), .ackP(ackP), .ackOvf(ackOvf),
    .hitA(hitA), .hitP(hitP), .pZero(pZero), .atMax(atMax),
    .underA(underA), .underP(underP),
    .strobe(strobe), .timerPin(timerPin),
    .flagA(flagA), .flagP(flagP), .flagOvf(flagOvf)
  );

  a_r9_timer_pin_low: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0 || modeSel == 2'd3) |-> !timerPin);
endmodule

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, outCtl = 0, outPol = 0, dutySwap = 0, clrSelA = 0;
  logic [1:0] modeSel = 0;
  logic [9:0] cmpA = 0;
  logic [2:0] cmpP = 0;
  logic ackA = 0, ackP = 0, ackOvf = 0;
  logic timerPin, flagA, flagP, flagOvf;

  int checks = 0, fails = 0;
  bit done = 0;
  string curTag = "";

  // bench model state
  int mCnt, mShA, mShP;
  bit mTog, mFa, mFp, mFo;

  always #4 clk = ~clk;

  dual_cmp_timer u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .modeSel(modeSel), .outCtl(outCtl),
    .outPol(outPol), .dutySwap(dutySwap), .clrSelA(clrSelA), .cmpA(cmpA),
    .cmpP(cmpP), .ackA(ackA), .ackP(ackP), .ackOvf(ackOvf),
    .timerPin(timerPin), .flagA(flagA), .flagP(flagP), .flagOvf(flagOvf)
  );

  function automatic bit mHitA(); return mCnt == mShA; endfunction
  function automatic bit mHitP(); return (mShP != 0) && (mCnt == mShP * 128); endfunction
  function automatic bit mClr();
    bit selA = (modeSel == 2) ? dutySwap : clrSelA;
    if (selA) return mHitA();
    if (mShP == 0) return mCnt == 1023;
    return mHitP();
  endfunction

  function automatic bit expPin();
    bit active;
    case (modeSel)
      2'd1: return outCtl ^ mTog ^ outPol;
      2'd2: begin
        if (!runEn) return outCtl ^ outPol;
        active = dutySwap ? (mCnt < mShP * 128) : (mCnt < mShA);
        return (active ? outCtl : !outCtl) ^ outPol;
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic modelStep();
    bit sa = runEn && mHitA();
    bit sp = runEn && mHitP();
    bit so = runEn && (mCnt == 1023);
    bit c  = mClr();
    mFa = sa | (mFa & !ackA);
    mFp = sp | (mFp & !ackP);
    mFo = so | (mFo & !ackOvf);
    if (!runEn) begin
      mCnt = 0; mShA = cmpA; mShP = cmpP; mTog = 0;
    end else if (c) begin
      mCnt = 0; mShA = cmpA; mShP = cmpP;
      if (modeSel == 2'd1) mTog = !mTog;
    end else begin
      mCnt = mCnt + 1;
    end
  endtask

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string pinTag();
    if (curTag != "") return curTag;
    case (modeSel)
      2'd1: return outPol ? "R8" : "R5";
      2'd2: return outCtl ? "R7" : "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic checkAll();
    check(timerPin, expPin(), pinTag(), "timerPin");
    check(flagA, mFa, "R10", "flagA");
    check(flagP, mFp, "R10", "flagP");
    check(flagOvf, mFo, "R4", "flagOvf");
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      checkAll();
    end
  endtask

  task automatic setup(input bit [1:0] m, input bit oc, input bit pol, input bit sw,
                       input bit cs, input int a, input int p);
    runEn = 0; modeSel = m; outCtl = oc; outPol = pol; dutySwap = sw; clrSelA = cs;
    cmpA = 10'(a); cmpP = 3'(p);
    cycles(2);
    runEn = 1;
  endtask

  initial begin
    mCnt = 0; mShA = 0; mShP = 0; mTog = 0; mFa = 0; mFp = 0; mFo = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12: reset state
    check(flagA, 1'b0, "R12", "flagA after reset");
    check(flagP, 1'b0, "R12", "flagP after reset");
    check(flagOvf, 1'b0, "R12", "flagOvf after reset");
    check(timerPin, 1'b0, "R12", "timerPin after reset");

    curTag = "R2";  setup(2'd1, 0, 0, 0, 1, 4, 3);    cycles(40);
    curTag = "R3";  setup(2'd1, 0, 0, 0, 0, 900, 1);  cycles(300);
    curTag = "R4";  setup(2'd0, 1, 1, 0, 0, 1000, 0); cycles(2100);
    curTag = "R4";  setup(2'd1, 0, 0, 0, 0, 5, 0);    cycles(1100);
    curTag = "R11"; setup(2'd1, 1, 0, 0, 1, 20, 2);   cycles(6);
    cmpA = 10'd3; cycles(60);
    curTag = "R1";  runEn = 0; outCtl = 1; cycles(3);
    outCtl = 0; outPol = 1; cycles(2);
    curTag = "R7";  setup(2'd2, 1, 0, 0, 1, 40, 1);   cycles(400);
    curTag = "R6";  setup(2'd2, 0, 0, 1, 0, 200, 1);  cycles(450);
    curTag = "R6";  setup(2'd2, 0, 0, 1, 1, 60, 0);   cycles(150);
    curTag = "R8";  setup(2'd2, 1, 1, 0, 0, 64, 1);   cycles(300);
    curTag = "R9";  setup(2'd0, 1, 1, 0, 1, 7, 2);    cycles(50);

    curTag = "";
    for (int seg = 0; seg < 40; seg++) begin
      int len = 200 + ($urandom % 1000);
      int a = ($urandom % 2) ? ($urandom % 64) : ($urandom % 1024);
      setup(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            a, $urandom % 8);
      for (int k = 0; k < len; k++) begin
        ackA   = ($urandom % 16) == 0;
        ackP   = ($urandom % 16) == 0;
        ackOvf = ($urandom % 16) == 0;
        if (($urandom % 128) == 0) cmpA = 10'($urandom);
        if (($urandom % 128) == 0) cmpP = 3'($urandom);
        if (($urandom % 500) == 0) runEn = 0;
        else runEn = 1;
        cycles(1);
      end
      ackA = 0; ackP = 0; ackOvf = 0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule